// File: doc/BRIEF.md
# Leading Sign and Zero Counter

This block measures how far a fixed-point operand can be shifted left before it loses information. For one operand it produces two counts at once: the number of leading zero bits, and the number of redundant sign bits (the run of bits equal to the sign bit, minus one). Both counts are packed into a single 32-bit result. The redundant-sign count is the shift that block floating-point scaling applies to bring a block of samples to full dynamic range. The leading-zero count serves unsigned normalization.

A size select limits the measurement to the low 8, 16 or 32 bits of the operand. The counts are then taken from the top bit of that field, and the bits above it play no part. A zero flag reports an all-zero field. With the default parameter, the result, its valid strobe and the zero flag are registered and appear one clock after the input strobe. They hold their value while no new operand arrives.

Top module: `nrm_count_unit`

## Requirements
- R1: Result bits [15:0] hold the number of consecutive 0 bits counted down from the top bit of the selected field. An all-zero field gives the field width (8, 16 or 32).
- R2: When the top bit of the field is 0, result bits [31:16] hold the leading-zero count minus one. An all-zero 32-bit operand gives 32 in the low half and 31 in the high half.
- R3: When the top bit of the field is 1, result bits [31:16] hold the number of leading 1 bits minus one. An all-ones field gives the field width minus one (7, 15 or 31).
- R4: The unsigned count sits in result bits [15:0] and the signed count in bits [31:16]. Both are zero-extended.
- R5: The size select encodes 2'b00 as byte (bits [7:0]), 2'b01 as word (bits [15:0]), and 2'b10 or 2'b11 as long (bits [31:0]). Operand bits above the selected field do not affect any output.
- R6: The zero flag is 1 exactly when the selected field of the operand is zero.
- R7: The valid output, result and zero flag for an operand presented with the valid input appear on the clock edge after it. Valid is low one cycle after a cycle with no valid input.
- R8: After reset, valid, result and zero flag are 0. Result and zero flag keep their last values while the valid input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_size | input | 2 | Field size select (00 byte, 01 word, 1x long) |
| in_operand | input | 32 | Operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Packed counts: [31:16] signed, [15:0] unsigned |
| out_zero | output | 1 | Selected field is zero |

## Verification
Every operand is driven at a falling edge and captured at the next rising edge. Its counts, zero flag and strobe are therefore due one cycle later, and the bench samples them at the following falling edge. A behavioural model in the bench computes the expected counts by walking the field bit by bit. Each output is compared against that model in the cycle it falls due, and in idle cycles the bench checks that the strobe is low and that the result has not moved.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_WORD     = 2'b01,
        SZ_LONG     = 2'b10,
        SZ_LONG_ALT = 2'b11
    } size_e;

    typedef struct packed {
        logic [HALF_W-1:0] sgn;
        logic [HALF_W-1:0] uns;
    } nrm_result_t;

    function automatic logic [CNT_W-1:0] field_width(size_e sz);
        case (sz)
            SZ_BYTE: field_width = CNT_W'(8);
            SZ_WORD: field_width = CNT_W'(16);
            default: field_width = CNT_W'(DATA_W);
        endcase
    endfunction
endpackage

// File: rtl/nrm_lzc.sv
module nrm_lzc #(
    parameter int WIDTH = 32,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    count
);
    logic found;

    always_comb begin
        count = CW'(WIDTH);
        found = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                count = CW'(WIDTH - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nrm_count_core.sv
module nrm_count_core
    import nrm_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  size_e             size,
    output nrm_result_t       res,
    output logic              is_zero
);
    logic [CNT_W-1:0]  width;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] sign_diff;
    logic [CNT_W-1:0]  lz_raw;
    logic [CNT_W-1:0]  ls_raw;
    logic [CNT_W-1:0]  lz_cnt;
    logic [CNT_W-1:0]  ls_cnt;

    // Left-justify the field so both counts start at bit DATA_W-1.
    always_comb begin
        width     = field_width(size);
        aligned   = operand << (CNT_W'(DATA_W) - width);
        sign_diff = aligned ^ {DATA_W{aligned[DATA_W-1]}};
        is_zero   = (aligned == '0);
    end

    nrm_lzc #(.WIDTH(DATA_W)) u_lz_zero (.vec(aligned),   .count(lz_raw));
    nrm_lzc #(.WIDTH(DATA_W)) u_lz_sign (.vec(sign_diff), .count(ls_raw));

    // Padding below the field may extend a run; clamp to the field width.
    always_comb begin
        lz_cnt  = (lz_raw > width) ? width : lz_raw;
        ls_cnt  = (ls_raw > width) ? width : ls_raw;
        res.uns = HALF_W'(lz_cnt);
        res.sgn = HALF_W'(ls_cnt - CNT_W'(1));
    end

    always_comb begin
        a_r1_count_bound: assert (lz_cnt <= width);
    end
endmodule

// File: rtl/nrm_count_unit.sv
module nrm_count_unit
    import nrm_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_zero
);
    nrm_result_t core_res;
    logic        core_zero;

    nrm_count_core u_core (
        .operand (in_operand),
        .size    (size_e'(in_size)),
        .res     (core_res),
        .is_zero (core_zero)
    );

    generate
        if (REGISTERED) begin : g_reg
            nrm_result_t res_q;
            logic        zero_q;
            logic        valid_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q   <= '0;
                    zero_q  <= 1'b0;
                    valid_q <= 1'b0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid) begin
                        res_q  <= core_res;
                        zero_q <= core_zero;
                    end
                end
            end

            assign out_valid  = valid_q;
            assign out_result = res_q;
            assign out_zero   = zero_q;

            a_r7_latency: assert property (@(posedge clk)
                disable iff (rst) out_valid == ($past(in_valid) && !$past(rst)));
            a_r8_hold: assert property (@(posedge clk)
                disable iff (rst) (!$past(in_valid) && !$past(rst)) |->
                    ($stable(out_result) && $stable(out_zero)));
            a_r2_nonneg_rel: assert property (@(posedge clk)
                disable iff (rst) (out_valid && out_result[15:0] != 16'd0) |->
                    (out_result[31:16] == out_result[15:0] - 16'd1));
            a_r3_sign_bound: assert property (@(posedge clk)
                disable iff (rst) out_valid |-> (out_result[31:16] <= 16'(DATA_W - 1)));
            a_r6_zero_full: assert property (@(posedge clk)
                disable iff (rst) (out_valid && out_zero) |->
                    (out_result[15:0] inside {16'd8, 16'd16, 16'(DATA_W)}));
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_result = core_res;
            assign out_zero   = core_zero;
        end
    endgenerate
endmodule

// File: tb/nrm_count_unit_tb.sv
module nrm_count_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_size;
    logic [31:0] in_operand;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nrm_count_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_operand(in_operand), .out_valid(out_valid),
        .out_result(out_result), .out_zero(out_zero)
    );

    // Behavioural model: walk the field from its top bit.
    function automatic logic [32:0] model(logic [31:0] op, logic [1:0] sz);
        int w, uz, run;
        bit top;
        w   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        top = op[w-1];
        uz  = 0;
        while (uz < w && op[w-1-uz] == 1'b0) uz++;
        run = 0;
        while (run < w && op[w-1-run] == top) run++;
        model = {(uz == w), 16'(run - 1), 16'(uz)};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] op, logic [1:0] sz, string tag);
        logic [32:0] e;
        e = model(op, sz);
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_size = sz;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R7 valid"}, 64'(out_valid), 64'd1);
        chk({tag, " R4 result"}, 64'(out_result), 64'(e[31:0]));
        chk({tag, " R6 zero"}, 64'(out_zero), 64'(e[32]));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_size = 2'b10; in_operand = '0;
        repeat (3) @(negedge clk);
        chk("R8 reset valid", 64'(out_valid), 64'd0);
        chk("R8 reset result", 64'(out_result), 64'd0);
        chk("R8 reset zero", 64'(out_zero), 64'd0);
        rst = 1'b0;

        apply(32'h0000_0000, 2'b10, "R2 zero long");
        chk("R1 zero long count", 64'(out_result), 64'h001F_0020);
        apply(32'hFFFF_FFFF, 2'b10, "R3 ones long");
        chk("R3 ones long count", 64'(out_result), 64'h001F_0000);
        apply(32'h0000_0000, 2'b00, "R1 zero byte");
        chk("R1 zero byte count", 64'(out_result), 64'h0007_0008);
        apply(32'h0000_0000, 2'b01, "R1 zero word");
        apply(32'h0000_FFFF, 2'b01, "R3 ones word");
        chk("R3 ones word count", 64'(out_result), 64'h000F_0000);
        apply(32'h0000_00FF, 2'b00, "R3 ones byte");
        apply(32'h1234_5680, 2'b00, "R5 byte ignores upper");
        chk("R5 byte upper count", 64'(out_result), 64'h0000_0000);
        apply(32'hFFFF_FF00, 2'b00, "R5 byte upper zero");
        chk("R5 byte upper zero flag", 64'(out_zero), 64'd1);
        apply(32'hABCD_0001, 2'b01, "R5 word ignores upper");
        chk("R1 word count", 64'(out_result), 64'h000E_000F);
        apply(32'h0000_0001, 2'b11, "R5 long alt");
        apply(32'hFFFE_0000, 2'b10, "R3 neg long");
        chk("R3 neg long count", 64'(out_result), 64'h000E_0000);

        for (int i = 0; i < 32; i++) begin
            apply(32'h1 << i, 2'b10, "R1 single bit");
            apply(~(32'h1 << i), 2'b10, "R3 single clear");
        end

        begin
            logic [31:0] lf;
            lf = 32'hACE1_2468;
            for (int k = 0; k < 200; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                apply(lf >> (k % 29), 2'(k % 4), "R2 pattern");
            end
        end

        // R8 hold with changing inputs but no strobe
        begin
            logic [31:0] last_r;
            logic        last_z;
            apply(32'h0000_0100, 2'b10, "R8 setup");
            last_r = out_result; last_z = out_zero;
            in_operand = 32'h0; in_size = 2'b00;
            @(negedge clk);
            chk("R7 idle valid low", 64'(out_valid), 64'd0);
            chk("R8 hold result", 64'(out_result), 64'(last_r));
            chk("R8 hold zero", 64'(out_zero), 64'(last_z));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule